// File: doc/BRIEF.md
# Pseudo-Static RAM Refresh Controller

This block is the refresh logic for a dynamic memory array that sits behind a plain static-RAM style interface with separate, non-multiplexed address lines. The array has 256 rows, and each row has to be refreshed, or reached by an ordinary access, once per retention window of 4 ms. The controller watches chip enable, the write enable and the shared output-enable/refresh-strobe input. It issues one-cycle row-refresh requests to the array, each with the row to refresh, and it shows a busy flag while a refresh is in progress.

Three refresh sources feed one arbiter:
- A cycle with chip enable high and neither a read nor a write refreshes the row on the address inputs.
- A rising edge on the strobe while chip enable is low refreshes the row held in an internal row counter.
- When chip enable has been low long enough, an internal timer takes over. It walks the row counter at a fixed tick, so the whole array is covered within the retention window.

Ordinary reads and writes always come first. A refresh that collides with an access waits until the access is over.

Top module: `psr_refresh_top`

## Requirements
- R1: A cycle sampled with chipEn=1, oeStrobe=0 and writeEn=0 latches rowAddr. If no access follows, rowRefresh pulses high for one cycle two clock edges after that cycle, with refreshRow equal to the latched address.
- R2: A cycle with chipEn=1 and either oeStrobe=1 (read) or writeEn=1 (write) is an access. An access alone produces no rowRefresh pulse.
- R3: A rising edge of oeStrobe sampled while chipEn=0 produces exactly one refresh of the counter row, however many cycles the strobe stays high.
- R4: The internal row counter supplies the row for strobe and timer refreshes. It advances by one after each such refresh and wraps from ROWS-1 to 0.
- R5: Self refresh needs no strobe and no address. After chipEn has been low for IDLE_CYCLES consecutive cycles, the block issues one counter-row refresh every TICK_CYCLES cycles. The default TICK_CYCLES is RETENTION_CYCLES/ROWS.
- R6: Self refresh stops on the first clock edge that samples chipEn=1. Its idle timer restarts, and a timer request that has not yet been served is dropped.
- R7: When an access coincides with a pending refresh, the access is served first. The refresh stays pending and is issued on the first cycle without an access.
- R8: busy is high for exactly REF_LEN cycles, starting with the cycle in which rowRefresh is high. No new refresh is issued while busy is high, and then one further cycle passes before the next refresh can be issued.
- R9: Reset (rstN=0, asynchronous) clears rowRefresh, busy, the row counter (to row 0) and all pending requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chipEn | input | 1 | Chip enable, active high |
| oeStrobe | input | 1 | Output enable when chipEn=1; refresh strobe when chipEn=0 |
| writeEn | input | 1 | Write enable, active high |
| rowAddr | input | ROW_W (8) | Row address bits of the external address |
| rowRefresh | output | 1 | One-cycle request to refresh refreshRow |
| refreshRow | output | ROW_W (8) | Row to refresh |
| busy | output | 1 | A refresh is executing |

## Verification
The hardest state to reach is a refresh that is already pending at the moment an access begins. Reaching it means ending a refresh source and starting a read on adjacent clock edges.

The bench does this by raising the strobe while chip enable is low and then switching to a read on the very next negative edge, before the request can be issued. The same pattern is used after a chip-enable-only cycle, and again with reset arriving one edge after a strobe edge.

Counter wrap is reached by letting self refresh run through more than 256 ticks, with a short tick parameter.

// File: rtl/psr_refresh_pkg.sv
package psr_refresh_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic latchExt;   // capture the external row address
    logic issueExt;   // refresh the captured external row
    logic issueInt;   // refresh the counter row and advance the counter
  } refStrobes_t;
endpackage

// File: rtl/psr_refresh_dp.sv
module psr_refresh_dp
  import psr_refresh_pkg::*;
#(
  parameter int unsigned ROWS  = 256,
  localparam int unsigned ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  refStrobes_t      strobes,
  input  logic [ROW_W-1:0] rowAddr,
  output logic [ROW_W-1:0] refreshRow
);

  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  logic [ROW_W-1:0] rowCnt;
  logic [ROW_W-1:0] extRow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extRow <= '0;
    end else if (strobes.latchExt) begin
      extRow <= rowAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowCnt <= '0;
    end else if (strobes.issueInt) begin
      rowCnt <= (rowCnt == LAST_ROW) ? '0 : rowCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refreshRow <= '0;
    end else if (strobes.issueExt) begin
      refreshRow <= extRow;
    end else if (strobes.issueInt) begin
      refreshRow <= rowCnt;
    end
  end

  // R4: the counter moves only after an internal refresh was issued
  assert_counter_moves_on_issue_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rowCnt != $past(rowCnt)) |-> $past(strobes.issueInt));

  // R4: never issue both kinds at once
  assert_single_source_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.issueExt && strobes.issueInt));

endmodule

// File: rtl/psr_refresh_ctrl.sv
module psr_refresh_ctrl
  import psr_refresh_pkg::*;
#(
  parameter int unsigned IDLE_CYCLES = 64,
  parameter int unsigned TICK_CYCLES = 3125,
  parameter int unsigned REF_LEN     = 3,
  parameter int unsigned AUTO_Q      = 3,
  localparam int unsigned IDLE_W = $clog2(IDLE_CYCLES + 1),
  localparam int unsigned TICK_W = $clog2(TICK_CYCLES + 1),
  localparam int unsigned BUSY_W = $clog2(REF_LEN + 1),
  localparam int unsigned AQ_W   = $clog2(AUTO_Q + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        chipEn,
  input  logic        oeStrobe,
  input  logic        writeEn,
  output refStrobes_t strobes,
  output logic        rowRefresh,
  output logic        busy
);

  logic              oePrev;
  logic              extPend;
  logic [AQ_W-1:0]   autoCnt;
  logic              selfPend;
  logic              selfActive;
  logic [IDLE_W-1:0] idleCnt;
  logic [TICK_W-1:0] tickCnt;
  logic [BUSY_W-1:0] busyCnt;

  logic accessNow, ceOnly, strobeRise, canIssue;
  logic issueExt, issueAuto, issueSelf, issueAny, tickWrap;

  always_comb begin
    accessNow  = chipEn && (oeStrobe || writeEn);
    ceOnly     = chipEn && !oeStrobe && !writeEn;
    strobeRise = oeStrobe && !oePrev && !chipEn;
    canIssue   = (busyCnt == '0) && !accessNow;
    issueExt   = canIssue && extPend;
    issueAuto  = canIssue && !extPend && (autoCnt != '0);
    issueSelf  = canIssue && !extPend && (autoCnt == '0) && selfPend;
    issueAny   = issueExt || issueAuto || issueSelf;
    tickWrap   = selfActive && !chipEn && (tickCnt == TICK_W'(TICK_CYCLES - 1));
    strobes.latchExt = ceOnly;
    strobes.issueExt = issueExt;
    strobes.issueInt = issueAuto || issueSelf;
  end

  // strobe edge detector and the pending external request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oePrev  <= 1'b0;
      extPend <= 1'b0;
    end else begin
      oePrev <= oeStrobe;
      if (ceOnly)        extPend <= 1'b1;
      else if (issueExt) extPend <= 1'b0;
    end
  end

  // queue of strobe requests not yet served
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      autoCnt <= '0;
    end else begin
      case ({strobeRise && (autoCnt != AQ_W'(AUTO_Q)), issueAuto})
        2'b10:   autoCnt <= autoCnt + 1'b1;
        2'b01:   autoCnt <= autoCnt - 1'b1;
        default: autoCnt <= autoCnt;
      endcase
    end
  end

  // idle detector that switches self refresh on and off
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt    <= '0;
      selfActive <= 1'b0;
    end else if (chipEn) begin
      idleCnt    <= '0;
      selfActive <= 1'b0;
    end else if (idleCnt == IDLE_W'(IDLE_CYCLES - 1)) begin
      selfActive <= 1'b1;
    end else begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  // self-refresh tick timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt  <= '0;
      selfPend <= 1'b0;
    end else if (chipEn || !selfActive) begin
      tickCnt  <= '0;
      selfPend <= 1'b0;
    end else begin
      tickCnt <= tickWrap ? '0 : tickCnt + 1'b1;
      if (tickWrap)       selfPend <= 1'b1;
      else if (issueSelf) selfPend <= 1'b0;
    end
  end

  // execution of a refresh
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt    <= '0;
      rowRefresh <= 1'b0;
    end else begin
      rowRefresh <= issueAny;
      if (issueAny)              busyCnt <= BUSY_W'(REF_LEN);
      else if (busyCnt != '0)    busyCnt <= busyCnt - 1'b1;
    end
  end

  assign busy = (busyCnt != '0);

  // R7: a refresh is never issued in a cycle that carried an access
  assert_no_refresh_on_access_R7: assert property (@(posedge clk) disable iff (!rstN)
    rowRefresh |-> $past(!(chipEn && (oeStrobe || writeEn))));

  // R8: a refresh request always comes with busy
  assert_busy_with_refresh_R8: assert property (@(posedge clk) disable iff (!rstN)
    rowRefresh |-> busy);

  // R8: no back-to-back refresh requests
  assert_no_back_to_back_R8: assert property (@(posedge clk) disable iff (!rstN)
    rowRefresh |=> !rowRefresh);

  // R6: chip enable ends self refresh at the next edge
  assert_self_stops_R6: assert property (@(posedge clk) disable iff (!rstN)
    chipEn |=> !selfActive);

  // R5: timer requests exist only while self refresh is active
  assert_self_pend_needs_active_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selfPend) |-> $past(selfActive));

endmodule

// File: rtl/psr_refresh_top.sv
module psr_refresh_top #(
  parameter int unsigned ROWS             = 256,
  parameter int unsigned RETENTION_CYCLES = 800000,
  parameter int unsigned TICK_CYCLES      = RETENTION_CYCLES / ROWS,
  parameter int unsigned IDLE_CYCLES      = 64,
  parameter int unsigned REF_LEN          = 3,
  parameter int unsigned AUTO_Q           = 3,
  localparam int unsigned ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipEn,
  input  logic             oeStrobe,
  input  logic             writeEn,
  input  logic [ROW_W-1:0] rowAddr,
  output logic             rowRefresh,
  output logic [ROW_W-1:0] refreshRow,
  output logic             busy
);

  psr_refresh_pkg::refStrobes_t strobes;

  psr_refresh_ctrl #(
    .IDLE_CYCLES(IDLE_CYCLES),
    .TICK_CYCLES(TICK_CYCLES),
    .REF_LEN    (REF_LEN),
    .AUTO_Q     (AUTO_Q)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .chipEn    (chipEn),
    .oeStrobe  (oeStrobe),
    .writeEn   (writeEn),
    .strobes   (strobes),
    .rowRefresh(rowRefresh),
    .busy      (busy)
  );

  psr_refresh_dp #(
    .ROWS(ROWS)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .rowAddr   (rowAddr),
    .refreshRow(refreshRow)
  );

endmodule

// File: tb/test_psr_refresh_top.sv
`timescale 1ns/1ps
module test_psr_refresh_top;

  localparam int ROWS = 256;
  localparam int IDLE = 60;
  localparam int TICK = 8;
  localparam int RLEN = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       chipEn = 1'b1;
  logic       oeStrobe = 1'b1;
  logic       writeEn = 1'b0;
  logic [7:0] rowAddr = '0;
  logic       rowRefresh;
  logic [7:0] refreshRow;
  logic       busy;

  int nChecks = 0;
  int nBad = 0;
  int cyc = 0;
  int logN = 0;
  int logRow [0:599];
  int logCyc [0:599];
  bit finished = 0;

  always #2.5 clk = ~clk;

  psr_refresh_top #(
    .ROWS(ROWS), .TICK_CYCLES(TICK), .IDLE_CYCLES(IDLE), .REF_LEN(RLEN)
  ) i_psr_refresh_top (
    .clk(clk), .rstN(rstN), .chipEn(chipEn), .oeStrobe(oeStrobe),
    .writeEn(writeEn), .rowAddr(rowAddr), .rowRefresh(rowRefresh),
    .refreshRow(refreshRow), .busy(busy)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rowRefresh && logN < 600) begin
      logRow[logN] = int'(refreshRow);
      logCyc[logN] = cyc;
      logN = logN + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readIdle();
    chipEn = 1'b1; oeStrobe = 1'b1; writeEn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    readIdle();
    rstN = 1'b0;
    waitN(3);
    rstN = 1'b1;
    logN = 0;
    waitN(1);
  endtask

  // R9: state right after reset
  task automatic testReset();
    doReset();
    chk(rowRefresh == 1'b0, "R9 rowRefresh after reset", int'(rowRefresh), 0);
    chk(busy == 1'b0, "R9 busy after reset", int'(busy), 0);
  endtask

  // R1, R8: CE-only refresh, latency and busy length
  task automatic testCeOnly();
    int busyHigh;
    doReset();
    chipEn = 1'b1; oeStrobe = 1'b0; writeEn = 1'b0; rowAddr = 8'h5A;
    @(negedge clk);
    chipEn = 1'b0;
    chk(rowRefresh == 1'b0, "R1 no pulse one edge after", int'(rowRefresh), 0);
    @(negedge clk);
    chk(rowRefresh == 1'b1, "R1 pulse two edges after", int'(rowRefresh), 1);
    chk(refreshRow == 8'h5A, "R1 refreshRow", int'(refreshRow), 'h5A);
    busyHigh = 0;
    for (int i = 0; i < 8; i++) begin
      if (busy) busyHigh++;
      @(negedge clk);
    end
    chk(busyHigh == RLEN, "R8 busy length", busyHigh, RLEN);
    chk(logN == 1, "R1 exactly one refresh", logN, 1);
    readIdle();
    // R8: two CE-only cycles in a row, second waits out busy
    doReset();
    chipEn = 1'b1; oeStrobe = 1'b0; rowAddr = 8'h11;
    @(negedge clk);
    rowAddr = 8'h22;
    @(negedge clk);
    chipEn = 1'b0;
    waitN(10);
    chk(logN == 2, "R8 two refreshes", logN, 2);
    chk(logRow[0] == 'h11 && logRow[1] == 'h22, "R8 rows in order", logRow[1], 'h22);
    chk(logCyc[1] - logCyc[0] == RLEN + 1, "R8 spacing", logCyc[1] - logCyc[0], RLEN + 1);
    readIdle();
  endtask

  // R2: reads and writes alone never refresh
  task automatic testAccess();
    doReset();
    for (int i = 0; i < 20; i++) begin
      chipEn = 1'b1; rowAddr = 8'(i * 13);
      oeStrobe = (i % 2 == 0); writeEn = (i % 2 == 1);
      @(negedge clk);
    end
    readIdle();
    waitN(4);
    chk(logN == 0, "R2 no refresh from access", logN, 0);
    chk(busy == 1'b0, "R2 busy stays low", int'(busy), 0);
  endtask

  // R3, R4: strobe pulses of several lengths
  task automatic testAuto();
    int lens [3] = '{1, 5, 2};
    doReset();
    chipEn = 1'b0; oeStrobe = 1'b0;
    waitN(2);
    for (int p = 0; p < 3; p++) begin
      oeStrobe = 1'b1;
      waitN(lens[p]);
      oeStrobe = 1'b0;
      waitN(5);
    end
    chk(logN == 3, "R3 one refresh per pulse", logN, 3);
    chk(logRow[0] == 0 && logRow[1] == 1 && logRow[2] == 2, "R4 counter rows 0,1,2", logRow[2], 2);
    readIdle();
  endtask

  // R5, R4, R6: self refresh, wrap and stop
  task automatic testSelf();
    int startCyc, badRow, badGap, snap;
    doReset();
    chipEn = 1'b0; oeStrobe = 1'b0;
    startCyc = cyc;
    waitN(IDLE - 10);
    chk(logN == 0, "R5 no self refresh before idle time", logN, 0);
    for (int w = 0; w < IDLE + 260 * TICK + 100 && logN < 258; w++) @(negedge clk);
    chk(logN >= 258, "R5 self refresh count", logN, 258);
    chk(logCyc[0] - startCyc >= IDLE && logCyc[0] - startCyc <= IDLE + TICK + 4,
        "R5 first self refresh time", logCyc[0] - startCyc, IDLE + TICK);
    badRow = 0; badGap = 0;
    for (int i = 0; i < 258; i++) begin
      if (logRow[i] != i % ROWS) badRow++;
      if (i > 0 && logCyc[i] - logCyc[i-1] != TICK) badGap++;
    end
    chk(badRow == 0, "R4 sequential rows with wrap", badRow, 0);
    chk(logRow[256] == 0, "R4 wrap to row 0", logRow[256], 0);
    chk(badGap == 0, "R5 tick spacing", badGap, 0);
    readIdle();
    waitN(3);
    snap = logN;
    waitN(50);
    chk(logN == snap, "R6 stops with chip enable", logN, snap);
    chipEn = 1'b0; oeStrobe = 1'b0;
    waitN(IDLE - 20);
    chk(logN == snap, "R6 idle timer restarted", logN, snap);
    readIdle();
  endtask

  // R7: access preempts pending refreshes
  task automatic testCollision();
    doReset();
    chipEn = 1'b0; oeStrobe = 1'b0;
    @(negedge clk);
    oeStrobe = 1'b1;
    @(negedge clk);
    readIdle();
    waitN(10);
    chk(logN == 0, "R7 strobe refresh held during access", logN, 0);
    chipEn = 1'b0; oeStrobe = 1'b0;
    waitN(5);
    chk(logN == 1 && logRow[0] == 0, "R7 held strobe refresh served", logN, 1);
    readIdle();
    waitN(6);
    chipEn = 1'b1; oeStrobe = 1'b0; rowAddr = 8'h33;
    @(negedge clk);
    readIdle();
    waitN(8);
    chk(logN == 1, "R7 CE-only refresh held during access", logN, 1);
    chipEn = 1'b0; oeStrobe = 1'b0;
    waitN(5);
    chk(logN == 2 && logRow[1] == 'h33, "R7 held CE-only row", logRow[1], 'h33);
    readIdle();
  endtask

  // R9: reset drops a pending request and clears the counter
  task automatic testResetPending();
    int snap;
    doReset();
    chipEn = 1'b0; oeStrobe = 1'b0;
    @(negedge clk);
    oeStrobe = 1'b1;
    @(negedge clk);
    rstN = 1'b0;
    readIdle();
    waitN(2);
    rstN = 1'b1;
    snap = logN;
    waitN(10);
    chk(logN == snap, "R9 pending cleared by reset", logN, snap);
    chipEn = 1'b0; oeStrobe = 1'b0;
    @(negedge clk);
    oeStrobe = 1'b1;
    waitN(6);
    chk(logN == snap + 1 && logRow[snap] == 0, "R9 counter back at row 0", logRow[snap], 0);
    readIdle();
  endtask

  initial begin
    testReset();
    testCeOnly();
    testAccess();
    testAuto();
    testSelf();
    testCollision();
    testResetPending();
    finished = 1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nBad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

endmodule